// File: doc/BRIEF.md
# Masked Pin-Change Interrupt Detector

This block watches a group of general-purpose input pins and raises one shared interrupt flag whenever any pin that software has enabled changes level, in either direction. Each pin is first captured in a register stage and then passed through a clock-domain synchroniser. After the synchroniser, the pin is gated by its bit in a mask register. The gated value is compared with its value one clock earlier. When any of the compare results shows a difference, the block produces a single-cycle set pulse, and that pulse sets a sticky group flag.

Software reaches the mask, the group enable and the flag through a small register port with one-cycle writes and combinational reads. The flag stays set until software writes a one to it. The interrupt request output is the flag gated by the group enable. Vectoring, the global interrupt enable and pin direction control are handled elsewhere.

Top module: `pin_change_irq`

## Requirements
- R1: After reset, the mask register (address 0), the enable bit (address 1, bit 0), the flag (address 2, bit 0) and `irq` all read zero, and no change is detected while the pins stay at the idle level (all zero).
- R2: A level change on an enabled pin, applied between clock edges, sets the flag on the fifth rising edge after it is applied. The flag still reads zero after the fourth edge.
- R3: A level change on a pin whose mask bit (address 0, bit i for pin i) is zero never sets the flag.
- R4: Both rising and falling changes are detected, on every one of the pins.
- R5: When several enabled pins change in the same cycle, they set the single shared flag, and one clear leaves that flag at zero.
- R6: Writing to address 2 with data bit 0 set clears the flag at the next edge. Writing with data bit 0 at zero leaves the flag unchanged.
- R7: If a set pulse and a clear write fall on the same clock edge, the flag ends up set.
- R8: `irq` is high exactly when the flag is set and the enable bit (address 1, bit 0) is one.
- R9: `reg_rdata` shows the register selected by `reg_addr`: address 0 gives the mask, address 1 gives the enable in bit 0, address 2 gives the flag in bit 0, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins | input | NPINS | Watched input pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | NPINS | Register write data |
| reg_rdata | output | NPINS | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
A pin change passes through the capture stage, two synchroniser stages, the set-pulse register and the flag register. The flag is therefore due on the fifth rising edge after the stimulus. The bench drives pins on falling edges and counts rising edges. It checks the flag as still clear after the fourth edge and as set after the fifth. Register writes take effect one edge after the strobe, so their results are read at the following falling edge. For the case where set and clear collide, the clear strobe is raised just before the fifth edge, so that both land on that same edge.

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int NPINS = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [NPINS-1:0] IDLE_LEVEL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [NPINS-1:0] reg_wdata,
  output logic [NPINS-1:0] reg_rdata,
  output logic             irq
);

  localparam logic [1:0] A_MASK = 2'd0;
  localparam logic [1:0] A_EN   = 2'd1;
  localparam logic [1:0] A_FLAG = 2'd2;

  logic [NPINS-1:0] cap_q;
  logic [NPINS-1:0] sync_q [SYNC_STAGES];
  logic [NPINS-1:0] mask_q, gated, gated_d;
  logic             en_q, set_q, flag_q, clr;

  assign gated = sync_q[SYNC_STAGES-1] & mask_q;
  assign clr   = reg_wr && reg_addr == A_FLAG && reg_wdata[0];
  assign irq   = flag_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= IDLE_LEVEL;
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= IDLE_LEVEL;
      gated_d <= '0;
      set_q   <= 1'b0;
    end else begin
      cap_q     <= pins;
      sync_q[0] <= cap_q;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      gated_d <= gated;
      set_q   <= |(gated ^ gated_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata;
      if (reg_wr && reg_addr == A_EN) en_q <= reg_wdata[0];
      flag_q <= set_q | (flag_q & ~clr);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MASK:  reg_rdata = mask_q;
      A_EN:    reg_rdata[0] = en_q;
      A_FLAG:  reg_rdata[0] = flag_q;
      default: reg_rdata = '0;
    endcase
  end

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_q |=> flag_q);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr |=> flag_q);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && clr && !set_q |=> !flag_q);

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_q && clr |=> flag_q);

  // R3
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_q && !flag_q |=> !flag_q);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q && en_q);

endmodule

// File: tb/test_pin_change_irq.sv
module test_pin_change_irq;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] pins = '0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 2'd2;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic irq;
  int compared = 0, mismatched = 0;
  bit done = 0;

  pin_change_irq #(.NPINS(N)) i_pin_change_irq (
    .clk(clk), .rst_n(rst_n), .pins(pins), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #10 clk = ~clk;

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 2'd2; reg_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [N-1:0] d);
    reg_addr = a; #1; d = reg_rdata; reg_addr = 2'd2; #1;
  endtask

  task automatic flip(string req, logic [N-1:0] bits, bit expect_set);
    @(negedge clk);
    pins = pins ^ bits;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({req, " R2 early"}, {7'd0, reg_rdata[0]}, '0);
    @(negedge clk);
    check(req, {7'd0, reg_rdata[0]}, {7'd0, expect_set});
    repeat (3) @(negedge clk);
    check({req, " settled"}, {7'd0, reg_rdata[0]}, {7'd0, expect_set});
    if (expect_set) begin
      wr(2'd2, 1);
      check("R6 clear", {7'd0, reg_rdata[0]}, '0);
    end
  endtask

  initial begin
    logic [N-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
    rd(0, d); check("R1 mask", d, '0);
    rd(1, d); check("R1 en", d, '0);
    rd(2, d); check("R1 flag", d, '0);
    check("R1 irq", {7'd0, irq}, '0);
    rd(3, d); check("R9 addr3", d, '0);

    for (int p = 0; p < N; p++) begin
      wr(0, ~(N'(1) << p));
      rd(0, d); check("R9 mask rd", d, ~(N'(1) << p));
      flip("R3 masked rise", N'(1) << p, 0);
      flip("R3 masked fall", N'(1) << p, 0);
    end
    wr(0, '1);
    for (int p = 0; p < N; p++) begin
      flip("R4 rise", N'(1) << p, 1);
      flip("R4 fall", N'(1) << p, 1);
    end
    flip("R5 multi rise", 8'hA5, 1);
    flip("R5 multi fall", 8'hA5, 1);

    flip("R6 setup", 8'h01, 1);
    pins = pins ^ 8'h01;
    repeat (6) @(negedge clk);
    wr(2, 0);
    check("R6 write zero", {7'd0, reg_rdata[0]}, 1);
    check("R8 irq disabled", {7'd0, irq}, 0);
    wr(1, 1);
    rd(1, d); check("R9 en rd", d, 1);
    check("R8 irq on", {7'd0, irq}, 1);
    wr(2, 1);
    check("R8 irq after clear", {7'd0, irq}, 0);

    @(negedge clk);
    pins = pins ^ 8'h02;
    repeat (4) @(posedge clk);
    @(negedge clk);
    reg_wr = 1; reg_addr = 2; reg_wdata = 1;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
    check("R7 set wins", {7'd0, reg_rdata[0]}, 1);
    wr(2, 1);
    check("R7 cleared after", {7'd0, reg_rdata[0]}, 0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected finish");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule